// File: doc/BRIEF.md
# Torus Dateline Virtual-Channel Route Computer

This block decides, for one router node of a unidirectional two-dimensional torus (four nodes per ring by default), where a packet's head flit goes next and on which virtual-channel level. The inputs are the node's own coordinates, the packet's destination coordinates and the level the packet currently travels on. The result is one of three output directions (+X, +Y, local eject) and the level for the next hop.

Routing is dimension-ordered: X is corrected fully before Y. Each ring closes through a wrap-around link, the hop from the highest coordinate back to zero. Crossing that link moves the packet to the next higher level. Levels therefore never fall along a route, so the channel dependence graph stays acyclic and the torus cannot deadlock. Two dimensions need levels 0, 1 and 2. An input level above 2 is flagged as an error.

The block sits between a head-flit source and a downstream allocator, joined on each side by a valid/ready handshake. It has a single output register.

Top module: `torus_vc_route`

## Requirements
- R1: When cur_x differs from dst_x, the result port is +X, code 0.
- R2: When cur_x equals dst_x and cur_y differs from dst_y, the result port is +Y, code 1.
- R3: When both coordinates match the destination, the result port is eject, code 2, and out_level equals in_level.
- R4: A +X hop taken from cur_x = 3 (the wrap link) gives out_level = in_level + 1. Every other +X hop keeps the level.
- R5: A +Y hop taken from cur_y = 3 gives out_level = in_level + 1. Every other +Y hop keeps the level.
- R6: Over a full walk from level 0, the level never decreases. The walk reaches eject after exactly ((dx-sx) mod 4) + ((dy-sy) mod 4) hops, and the level at eject equals the number of wrap hops taken (at most 2).
- R7: out_err is 1 when in_level > 2, or when a wrap would raise the level above 2. In that case out_level = in_level and the port follows R1 to R3.
- R8: A head accepted (in_valid and in_ready high at a clock edge) appears with out_valid = 1 right after that edge.
- R9: While out_valid = 1 and out_ready = 0, in_ready is 0 and out_port, out_level and out_err hold their values.
- R10: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Head flit offered |
| in_ready | output | 1 | Head flit can be taken |
| cur_x | input | 2 | This node's X coordinate |
| cur_y | input | 2 | This node's Y coordinate |
| dst_x | input | 2 | Destination X coordinate |
| dst_y | input | 2 | Destination Y coordinate |
| in_level | input | 2 | Packet's current VC level |
| out_valid | output | 1 | Route result present |
| out_ready | input | 1 | Downstream takes the result |
| out_port | output | 2 | 0 = +X, 1 = +Y, 2 = eject |
| out_level | output | 2 | VC level for the next hop |
| out_err | output | 1 | Level out of range |

## Verification
The bench walks every source/destination pair of the 4x4 torus hop by hop from level 0. It feeds each result back as the next node. This separates routes that wrap in X, in Y, in both, or in neither, and checks that hop counts and final levels match the ring distances. A second pattern sends random heads with random levels, including the illegal level 3 and level 2 at a wrap node, so the error cases are separated from legal increments. A third pattern toggles out_ready while heads are offered back to back, so holding a result is told apart from overwriting it. A behavioural model is compared on every clock across all three patterns.

// File: rtl/tvr_pkg.sv
// Package: shared defaults and output port codes for the torus route computer.
// Assumes a unidirectional torus whose port code equals the dimension index,
// with eject coded just above the last dimension.
package tvr_pkg;
    localparam int TVR_RADIX = 4;
    localparam int TVR_NDIM  = 2;
    localparam int TVR_LW    = 2;

    localparam logic [1:0] PORT_XP    = 2'd0;
    localparam logic [1:0] PORT_YP    = 2'd1;
    localparam logic [1:0] PORT_EJECT = 2'd2;
endpackage

// File: rtl/tvr_dim_cmp.sv
// Module: per-dimension comparator. It reports whether this dimension still
// needs a hop and whether the node sits at the ring's wrap link
// (highest coordinate to zero). Assumes coordinates are below RADIX.
module tvr_dim_cmp #(
    parameter int RADIX = 4,
    parameter int CW    = $clog2(RADIX)
) (
    input  logic [CW-1:0] cur,
    input  logic [CW-1:0] dst,
    output logic          need_hop,
    output logic          on_wrap
);
    localparam logic [CW-1:0] LAST = CW'(RADIX - 1);

    // Purpose: compare the coordinate with the destination and the ring end.
    always_comb begin
        need_hop = (cur != dst);
        on_wrap  = (cur == LAST);
    end
endmodule

// File: rtl/tvr_route_sel.sv
// Module: dimension-order selector. The lowest dimension that still needs a
// hop wins. A wrap hop raises the level by one. Levels above MAX_LVL on input,
// or reached by the increment, raise err and keep the input level.
// Assumes the port code equals the dimension index and eject is NDIM.
module tvr_route_sel #(
    parameter int NDIM    = 2,
    parameter int LW      = 2,
    parameter int MAX_LVL = NDIM,
    parameter int PW      = $clog2(NDIM + 1)
) (
    input  logic [NDIM-1:0] need_hop,
    input  logic [NDIM-1:0] on_wrap,
    input  logic [LW-1:0]   in_level,
    output logic [PW-1:0]   port,
    output logic [LW-1:0]   level,
    output logic            err
);
    logic          found;
    logic          wrap_hop;
    logic [LW:0]   bumped;

    // Purpose: pick the first unfinished dimension, or eject when none is left.
    always_comb begin
        found    = 1'b0;
        wrap_hop = 1'b0;
        port     = PW'(NDIM);
        for (int d = 0; d < NDIM; d++) begin
            if (!found && need_hop[d]) begin
                found    = 1'b1;
                port     = PW'(d);
                wrap_hop = on_wrap[d];
            end
        end
    end

    // Purpose: compute the next level and the out-of-range flag.
    always_comb begin
        bumped = {1'b0, in_level} + {{LW{1'b0}}, wrap_hop};
        err    = ({1'b0, in_level} > (LW+1)'(MAX_LVL)) || (bumped > (LW+1)'(MAX_LVL));
        level  = err ? in_level : bumped[LW-1:0];
    end
endmodule

// File: rtl/tvr_out_stage.sv
// Module: single result register with a valid/ready handshake. It loads when
// a head is taken and keeps its value until the downstream side takes it.
// Assumes take is only high when ready is high.
module tvr_out_stage #(
    parameter int PW = 2,
    parameter int LW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          out_ready,
    input  logic [PW-1:0] d_port,
    input  logic [LW-1:0] d_level,
    input  logic          d_err,
    output logic          ready,
    output logic          q_valid,
    output logic [PW-1:0] q_port,
    output logic [LW-1:0] q_level,
    output logic          q_err
);
    // Purpose: the register is free when empty or being drained this cycle.
    always_comb ready = !q_valid || out_ready;

    // Purpose: track whether a result is held.
    always_ff @(posedge clk) begin
        if (!rst_n)         q_valid <= 1'b0;
        else if (take)      q_valid <= 1'b1;
        else if (out_ready) q_valid <= 1'b0;
    end

    // Purpose: capture the route result of a taken head.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_port  <= '0;
            q_level <= '0;
            q_err   <= 1'b0;
        end else if (take) begin
            q_port  <= d_port;
            q_level <= d_level;
            q_err   <= d_err;
        end
    end
endmodule

// File: rtl/torus_vc_route.sv
// Module: route computer for one node of a unidirectional 2-D torus with
// per-wrap virtual-channel levels. It packs the coordinates per dimension,
// compares each dimension, selects in dimension order and registers the result.
// Assumes coordinates are below RADIX.
module torus_vc_route
    import tvr_pkg::*;
#(
    parameter int RADIX = TVR_RADIX,
    parameter int LW    = TVR_LW
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [$clog2(RADIX)-1:0]   cur_x,
    input  logic [$clog2(RADIX)-1:0]   cur_y,
    input  logic [$clog2(RADIX)-1:0]   dst_x,
    input  logic [$clog2(RADIX)-1:0]   dst_y,
    input  logic [LW-1:0]              in_level,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [1:0]                 out_port,
    output logic [LW-1:0]              out_level,
    output logic                       out_err
);
    localparam int NDIM = TVR_NDIM;
    localparam int CW   = $clog2(RADIX);
    localparam int PW   = $clog2(NDIM + 1);

    logic [CW-1:0]   cur_c [NDIM];
    logic [CW-1:0]   dst_c [NDIM];
    logic [NDIM-1:0] need_hop;
    logic [NDIM-1:0] on_wrap;
    logic [PW-1:0]   sel_port;
    logic [LW-1:0]   sel_level;
    logic            sel_err;
    logic            take;
    logic [PW-1:0]   q_port;

    // Purpose: gather the per-dimension coordinates in routing order.
    always_comb begin
        cur_c[0] = cur_x;
        cur_c[1] = cur_y;
        dst_c[0] = dst_x;
        dst_c[1] = dst_y;
    end

    for (genvar d = 0; d < NDIM; d++) begin : g_dim
        tvr_dim_cmp #(.RADIX(RADIX), .CW(CW)) cmp_i (
            .cur      (cur_c[d]),
            .dst      (dst_c[d]),
            .need_hop (need_hop[d]),
            .on_wrap  (on_wrap[d])
        );
    end

    tvr_route_sel #(.NDIM(NDIM), .LW(LW), .MAX_LVL(NDIM), .PW(PW)) sel_i (
        .need_hop (need_hop),
        .on_wrap  (on_wrap),
        .in_level (in_level),
        .port     (sel_port),
        .level    (sel_level),
        .err      (sel_err)
    );

    // Purpose: a head is taken when offered and the register is free.
    always_comb take = in_valid && in_ready;

    tvr_out_stage #(.PW(PW), .LW(LW)) stage_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .out_ready (out_ready),
        .d_port    (sel_port),
        .d_level   (sel_level),
        .d_err     (sel_err),
        .ready     (in_ready),
        .q_valid   (out_valid),
        .q_port    (q_port),
        .q_level   (out_level),
        .q_err     (out_err)
    );

    // Purpose: widen the port code to the 2-bit port field.
    always_comb out_port = 2'(q_port);
endmodule

// File: rtl/tvr_chk.sv
// Module: assertion checker for torus_vc_route, attached with bind.
// Assumes the default 2-bit coordinate and level fields.
module tvr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic [1:0] cur_x,
    input logic [1:0] cur_y,
    input logic [1:0] dst_x,
    input logic [1:0] dst_y,
    input logic [1:0] in_level,
    input logic       out_valid,
    input logic       out_ready,
    input logic [1:0] out_port,
    input logic [1:0] out_level,
    input logic       out_err
);
    logic acc;
    always_comb acc = in_valid && in_ready;

    assert_x_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cur_x != dst_x) |=> (out_port == 2'd0));

    assert_y_second_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cur_x == dst_x && cur_y != dst_y) |=> (out_port == 2'd1));

    assert_eject_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cur_x == dst_x && cur_y == dst_y) |=>
        (out_port == 2'd2 && out_level == $past(in_level)));

    assert_level_monotonic_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (out_level >= $past(in_level)));

    assert_bad_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_level == 2'd3) |=> out_err);

    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_valid);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
        (out_valid && $stable(out_port) && $stable(out_level) && $stable(out_err)));

    assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
endmodule

bind torus_vc_route tvr_chk chk_i (.*);

// File: tb/torus_vc_route_tb_top.sv
// Bench: behavioural reference compared on every clock, a full hop-by-hop
// walk of all pairs, random heads and a back-pressure phase.
module torus_vc_route_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic       in_ready;
    logic [1:0] cur_x, cur_y, dst_x, dst_y, in_level;
    logic       out_valid;
    logic       out_ready;
    logic [1:0] out_port;
    logic [1:0] out_level;
    logic       out_err;

    int tests = 0;
    int fails = 0;
    bit bp_mode = 0;
    bit done = 0;
    int cyc = 0;

    bit m_valid = 0;
    int m_port, m_level, m_err;

    always #10 clk = ~clk;

    torus_vc_route dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
        .in_level(in_level), .out_valid(out_valid), .out_ready(out_ready),
        .out_port(out_port), .out_level(out_level), .out_err(out_err)
    );

    function automatic void ref_route(input int cx, cy, dx, dy, lv,
                                      output int port, nl, err);
        int wrap;
        if (cx != dx)      begin port = 0; wrap = (cx == 3); end
        else if (cy != dy) begin port = 1; wrap = (cy == 3); end
        else               begin port = 2; wrap = 0; end
        nl  = lv + wrap;
        err = (lv > 2 || nl > 2) ? 1 : 0;
        if (err != 0) nl = lv;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model state update at each edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) m_valid <= 0;
        else if (in_valid && (!m_valid || out_ready)) begin
            int p, l, e;
            ref_route(cur_x, cur_y, dst_x, dst_y, in_level, p, l, e);
            m_valid <= 1; m_port <= p; m_level <= l; m_err <= e;
        end else if (out_ready) m_valid <= 0;
    end

    // Compare against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            string rq;
            rq = (m_err != 0) ? "R7" : (m_port == 0) ? "R1/R4" : (m_port == 1) ? "R2/R5" : "R3";
            check(out_valid == m_valid, "R8 out_valid", out_valid, m_valid);
            check(in_ready == (!m_valid || out_ready), "R9 in_ready", in_ready, !m_valid || out_ready);
            if (m_valid && out_valid) begin
                check(out_port == m_port, {rq, " port"}, out_port, m_port);
                check(out_level == m_level, {rq, " level"}, out_level, m_level);
                check(out_err == m_err, {"R7 err ", rq}, out_err, m_err);
            end
        end
    end

    // Back-pressure pattern on out_ready.
    always @(posedge clk) begin
        #5;
        if (bp_mode) out_ready = ((cyc % 3) != 0) ? $urandom_range(0, 1) : 1'b0;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic send(input int cx, cy, dx, dy, lv);
        bit acc;
        cur_x = 2'(cx); cur_y = 2'(cy); dst_x = 2'(dx); dst_y = 2'(dy); in_level = 2'(lv);
        in_valid = 1;
        do begin
            @(negedge clk); acc = in_ready;
            @(posedge clk); #5;
        end while (!acc);
        in_valid = 0;
    endtask

    initial begin
        rst_n = 0; in_valid = 0; out_ready = 1;
        cur_x = 0; cur_y = 0; dst_x = 0; dst_y = 0; in_level = 0;
        repeat (3) @(posedge clk);
        #5 rst_n = 1;
        @(negedge clk);
        check(out_valid == 0, "R10 out_valid after reset", out_valid, 0);
        check(in_ready == 1, "R10 in_ready after reset", in_ready, 1);
        @(posedge clk); #5;

        // Full walk of every pair from level 0 (R6, R4, R5).
        for (int s = 0; s < 16; s++) begin
            for (int t = 0; t < 16; t++) begin
                int x, y, lv, hops, wraps, ej;
                x = s % 4; y = s / 4; lv = 0; hops = 0; wraps = 0; ej = 0;
                while (!ej && hops < 10) begin
                    int pl;
                    pl = lv;
                    send(x, y, t % 4, t / 4, lv);
                    check(out_valid == 1, "R8 walk result present", out_valid, 1);
                    check(int'(out_level) >= pl, "R6 level not decreasing", out_level, pl);
                    if (out_port == 2'd2) ej = 1;
                    else begin
                        if (out_port == 2'd0) begin
                            check(int'(out_level) == pl + (x == 3), "R4 x wrap level", out_level, pl + (x == 3));
                            if (x == 3) wraps++;
                            x = (x + 1) % 4;
                        end else begin
                            check(int'(out_level) == pl + (y == 3), "R5 y wrap level", out_level, pl + (y == 3));
                            if (y == 3) wraps++;
                            y = (y + 1) % 4;
                        end
                        hops++;
                    end
                    lv = out_level;
                end
                check(hops == ((t % 4 - s % 4 + 4) % 4) + ((t / 4 - s / 4 + 4) % 4),
                      "R6 hop count", hops, ((t % 4 - s % 4 + 4) % 4) + ((t / 4 - s / 4 + 4) % 4));
                check(lv == wraps && lv <= 2, "R6 final level", lv, wraps);
            end
        end

        // Directed error cases (R7).
        send(3, 0, 1, 0, 2);
        @(negedge clk);
        check(out_err == 1 && out_level == 2 && out_port == 0, "R7 wrap at level 2", out_err, 1);
        @(posedge clk); #5;
        send(1, 1, 1, 1, 3);
        @(negedge clk);
        check(out_err == 1 && out_level == 3 && out_port == 2, "R7 level 3 eject", out_err, 1);
        @(posedge clk); #5;

        // Random heads with back-pressure (R9 and all per-cycle checks).
        bp_mode = 1;
        for (int i = 0; i < 300; i++)
            send($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                 $urandom_range(0, 3), $urandom_range(0, 3));
        bp_mode = 0;
        out_ready = 1;
        repeat (3) @(posedge clk);
        #5 done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule